// File: doc/BRIEF.md
# Runtime Frequency-to-Increment Multiplier

This block converts an integer frequency in hertz into the per-cycle increment that a phase-accumulator synthesizer adds to its phase. It multiplies the frequency word by a fixed-point scale constant and drops the constant's fraction bits from the product. The constant is chosen offline as 2^(accumulator width + fraction bits) divided by the system clock rate. The result is registered, so a single multiplier serves every frequency the system asks for while it runs.

A typical use is a tone generator. Software or a sequencer places a note frequency on the input, for example 261 Hz and later 440 Hz. The increment follows one clock later and feeds the accumulator. The defaults assume a 50 MHz clock, a 32-bit accumulator, 16 fraction bits and a 13-bit frequency word that covers 27 Hz to 4200 Hz and more. With 16 fraction bits the error at 27 Hz stays well inside 0.1 %.

Top module: `freq_inc_gen`

## Requirements
- R1: While `rst_n` is low the increment output is zero, and it goes to zero when reset is asserted without waiting for a clock edge.
- R2: After a rising clock edge with reset released, `incr_o` equals floor(SCALE × f / 2^FRAC_W), reduced modulo 2^ACC_W, where f is the value `freq_i` had at that edge and SCALE is the scale constant parameter.
- R3: The latency is exactly one edge. A new `freq_i` value leaves `incr_o` unchanged until the next rising edge and appears on it right after that edge.
- R4: A frequency of zero gives an increment of zero.
- R5: The full product is kept before truncation, so the largest frequency word (all ones) yields the exact truncated result with no high product bit lost.
- R6: While `freq_i` stays constant, `incr_o` stays constant from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_i | input | FREQ_W (13) | Target frequency in hertz, unsigned integer |
| incr_o | output | ACC_W (32) | Registered phase increment for the accumulator |

## Verification
Directed values test the musical notes 261 and 440, the ends of the 27 to 4200 Hz band, zero, and the all-ones word. The all-ones word shows whether the top product bits survive. Zero separates a real product from a stale register. A stretch of several hundred random frequencies from a fixed seed compares each result with a floor-division reference. This catches an off-by-one in the shift and a wrong slice. Mid-cycle probes before each edge separate one-edge latency from a combinational path or from an extra pipeline stage. A reset pulse asserted between edges shows whether the clear is asynchronous.

// File: rtl/freq_inc_pkg.sv
package freq_inc_pkg;
    // Default sizing: 50 MHz clock, 32-bit accumulator, 16 fraction bits.
    // Scale = round(2^(32+16) / 50e6) = 5629500.
    localparam int unsigned DEF_FREQ_W  = 13;
    localparam int unsigned DEF_ACC_W   = 32;
    localparam int unsigned DEF_FRAC_W  = 16;
    localparam int unsigned DEF_SCALE_W = 23;
    localparam logic [DEF_SCALE_W-1:0] DEF_SCALE = 23'd5629500;
endpackage

// File: rtl/freq_inc_mult.sv
module freq_inc_mult #(
    parameter int unsigned FREQ_W  = 13,
    parameter int unsigned SCALE_W = 23,
    parameter logic [SCALE_W-1:0] SCALE = '0,
    localparam int unsigned PROD_W = FREQ_W + SCALE_W
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic [PROD_W-1:0] prod_o
);
    // Full-width product: no bit of the product is dropped here.
    always_comb begin
        prod_o = PROD_W'(freq_i) * PROD_W'(SCALE);
    end
endmodule

// File: rtl/freq_inc_trim.sv
module freq_inc_trim #(
    parameter int unsigned PROD_W = 36,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned ACC_W  = 32,
    localparam int unsigned KEEP_W = PROD_W - FRAC_W
) (
    input  logic [PROD_W-1:0] prod_i,
    output logic [ACC_W-1:0]  incr_o
);
    generate
        if (KEEP_W >= ACC_W) begin : g_cut
            // Integer part wider than the accumulator: keep the low bits.
            assign incr_o = prod_i[FRAC_W +: ACC_W];
        end else begin : g_pad
            // Integer part narrower: zero-extend to the accumulator width.
            assign incr_o = {{(ACC_W - KEEP_W){1'b0}}, prod_i[PROD_W-1:FRAC_W]};
        end
    endgenerate
endmodule

// File: rtl/freq_inc_gen.sv
module freq_inc_gen
    import freq_inc_pkg::*;
#(
    parameter int unsigned FREQ_W  = DEF_FREQ_W,
    parameter int unsigned ACC_W   = DEF_ACC_W,
    parameter int unsigned FRAC_W  = DEF_FRAC_W,
    parameter int unsigned SCALE_W = DEF_SCALE_W,
    parameter logic [SCALE_W-1:0] SCALE = DEF_SCALE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_i,
    output logic [ACC_W-1:0]  incr_o
);
    localparam int unsigned PROD_W = FREQ_W + SCALE_W;
    localparam int unsigned KEEP_W = PROD_W - FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] incr;
    } state_t;

    state_t           st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  incr_new;

    freq_inc_mult #(
        .FREQ_W (FREQ_W),
        .SCALE_W(SCALE_W),
        .SCALE  (SCALE)
    ) mult_i (
        .freq_i(freq_i),
        .prod_o(prod)
    );

    freq_inc_trim #(
        .PROD_W(PROD_W),
        .FRAC_W(FRAC_W),
        .ACC_W (ACC_W)
    ) trim_i (
        .prod_i(prod),
        .incr_o(incr_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.incr = incr_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign incr_o = st_q.incr;

    // R1: output is clear whenever reset is low at an edge
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |-> (incr_o == '0));

    // R4: a zero frequency yields a zero increment one edge later
    p_zero_freq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_i == '0) |=> (incr_o == '0));

    // R6: constant input keeps the output constant
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(freq_i)) |=> $stable(incr_o));

    generate
        if (KEEP_W <= ACC_W) begin : g_range_chk
            localparam logic [PROD_W-1:0] MAX_PROD =
                PROD_W'({FREQ_W{1'b1}}) * PROD_W'(SCALE);
            localparam logic [ACC_W-1:0] MAX_INC =
                ACC_W'(MAX_PROD >> FRAC_W);
            // R5: no result above the all-ones product
            p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                incr_o <= MAX_INC);
        end
    endgenerate
endmodule

// File: tb/freq_inc_gen_tb.sv
module freq_inc_gen_tb_top;
    import freq_inc_pkg::*;

    localparam int unsigned FW = DEF_FREQ_W;
    localparam int unsigned AW = DEF_ACC_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] freq_i = '0;
    logic [AW-1:0] incr_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    freq_inc_gen dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .freq_i(freq_i),
        .incr_o(incr_o)
    );

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] ref_inc(input longint unsigned f);
        longint unsigned p;
        p = f * longint'(DEF_SCALE);
        p = p / (64'd1 << DEF_FRAC_W);
        return p[AW-1:0];
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_run++;
        if (incr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, incr_o, exp);
        end
    endtask

    // Drive at a falling edge, check at the following falling edge.
    task automatic apply(input string req, input logic [FW-1:0] f);
        @(negedge clk);
        freq_i = f;
        @(negedge clk);
        check(req, ref_inc(f));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] f;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset", '0);
        freq_i = 13'd261;
        @(negedge clk);
        check("R1 reset holds with input", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 261 Hz", ref_inc(261));

        apply("R2 440 Hz", 13'd440);
        apply("R2 27 Hz", 13'd27);
        apply("R2 4200 Hz", 13'd4200);
        apply("R4 zero", 13'd0);
        apply("R5 all ones", {FW{1'b1}});
        apply("R2 one", 13'd1);

        // R3: new value invisible until the next edge, then present
        @(negedge clk);
        freq_i = 13'd440;
        @(negedge clk);
        check("R3 after edge", ref_inc(440));
        freq_i = 13'd261;
        #5;
        check("R3 before edge", ref_inc(440));
        @(posedge clk);
        #1;
        check("R3 one edge", ref_inc(261));

        // R6: hold across several cycles
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R6 hold", ref_inc(261));
        end

        // Random band
        for (int i = 0; i < 300; i++) begin
            f = FW'($urandom);
            apply("R2 random", f);
        end

        // R1: async reset between edges
        @(negedge clk);
        freq_i = 13'd4200;
        @(negedge clk);
        #3;
        rst_n = 1'b0;
        #2;
        check("R1 async clear", '0);
        @(negedge clk);
        check("R1 held low", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset", ref_inc(4200));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule